// File: doc/BRIEF.md
# Palette Colour Loader with Auto-Advancing Index

This block holds a 256-entry colour lookup table for an indexed-colour display pipeline. Each entry has separate red, green and blue bytes. Software loads the table through a 16-byte register window on a 32-bit bus. One register selects the entry. A second register takes the colour bytes one write at a time: red first, then green, then blue. A small phase counter records which byte comes next. After the blue byte, the entry pointer moves on by one. A whole palette, or any run of adjacent entries, can therefore be streamed after a single index write.

The pixel pipeline looks up colours through a separate read port. It presents an index and receives the packed colour one clock later. Bus reads from the register window always return zero. Any bus write that is not a full-word write to one of the two defined registers is discarded. Such a write changes neither the table, the pointer nor the phase.

Top module: `pal_dac_port`

## Requirements
- R1: A full-word write to byte offset 0 loads the entry pointer from bits 31:24 of the write data and returns the phase to red, discarding any partly written entry sequence.
- R2: Full-word writes to byte offset 4 store bits 31:24 of the write data into the red, then green, then blue byte of the entry named by the pointer, in that order; bits 23:0 are ignored.
- R3: The write that stores blue also advances the pointer by one modulo 256 (255 wraps to 0) and returns the phase to red.
- R4: `bus_rdata` is zero at all times, including during and after writes.
- R5: A write whose byte enables `bus_be` are not all four set (4'hF) is ignored: table, pointer and phase keep their values.
- R6: After reset, entries 0 to 254 read as black (24'h000000), entry 255 reads as white (24'hFFFFFF), the pointer is 0 and the phase is red.
- R7: Writes to byte offsets 8 or 12, or to any address with bits 1:0 not zero, are ignored and change no state.
- R8: `pix_rgb` shows {red, green, blue} of the entry given by `pix_idx` one clock after `pix_idx` is sampled (red in bits 23:16, blue in bits 7:0). When a bus write updates that same entry on the same edge, the value from before that write is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 4 | Byte address within the register window |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always zero |
| pix_idx | input | 8 | Pixel lookup index |
| pix_rgb | output | 24 | Registered colour of the looked-up entry |

## Verification
The bench builds the block with its default parameters: an 8-bit pointer, 8-bit colour bytes, a 32-bit bus and a registered pixel read. With these values the pointer wrap from 255 to 0 needs only three writes after one index write. It also lets every one of the 256 reset values be read back through the pixel port in a few hundred cycles. The registered read variant is the one where a collision between a lookup and a write to the same entry has a defined old-value result. That result is checked cycle by cycle.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;

   localparam int unsigned NUM_COMP = 3;

   typedef enum logic [1:0] {
      PH_RED = 2'd0,
      PH_GRN = 2'd1,
      PH_BLU = 2'd2
   } comp_phase_e;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_INDEX = 2'd1,
      OP_DATA  = 2'd2
   } bus_op_e;

endpackage

// File: rtl/pal_dac_decode.sv
module pal_dac_decode
   import pal_dac_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned BE_W   = 4
) (
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BE_W-1:0]   be,
   output bus_op_e           op
);
   localparam int unsigned WORD_W = ADDR_W - 2;

   logic              full_word;
   logic              aligned;
   logic [WORD_W-1:0] word_sel;

   assign full_word = &be;
   assign aligned   = (addr[1:0] == 2'b00);
   assign word_sel  = addr[ADDR_W-1:2];

   always_comb begin
      op = OP_NONE;
      if (wr && full_word && aligned) begin
         if (word_sel == WORD_W'(0))      op = OP_INDEX;
         else if (word_sel == WORD_W'(1)) op = OP_DATA;
      end
   end
endmodule

// File: rtl/pal_dac_seq.sv
module pal_dac_seq
   import pal_dac_pkg::*;
#(
   parameter int unsigned IDX_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  bus_op_e             op,
   input  logic [IDX_W-1:0]    idx_in,
   output logic [IDX_W-1:0]    idx_q,
   output comp_phase_e         phase_q,
   output logic [NUM_COMP-1:0] comp_we
);
   logic [IDX_W-1:0] idx_d;
   comp_phase_e      phase_d;

   always_comb begin
      comp_we = '0;
      if (op == OP_DATA) begin
         unique case (phase_q)
            PH_RED:  comp_we = 3'b001;
            PH_GRN:  comp_we = 3'b010;
            PH_BLU:  comp_we = 3'b100;
            default: comp_we = '0;
         endcase
      end
   end

   always_comb begin
      idx_d   = idx_q;
      phase_d = phase_q;
      unique case (op)
         OP_INDEX: begin
            idx_d   = idx_in;
            phase_d = PH_RED;
         end
         OP_DATA: begin
            unique case (phase_q)
               PH_RED: phase_d = PH_GRN;
               PH_GRN: phase_d = PH_BLU;
               default: begin
                  phase_d = PH_RED;
                  idx_d   = idx_q + 1'b1;
               end
            endcase
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q   <= '0;
         phase_q <= PH_RED;
      end else begin
         idx_q   <= idx_d;
         phase_q <= phase_d;
      end
   end
endmodule

// File: rtl/pal_dac_store.sv
module pal_dac_store
   import pal_dac_pkg::*;
#(
   parameter int unsigned IDX_W   = 8,
   parameter int unsigned COMP_W  = 8,
   parameter bit          PIX_REG = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [NUM_COMP-1:0]        comp_we,
   input  logic [COMP_W-1:0]          wr_val,
   input  logic [IDX_W-1:0]           rd_idx,
   output logic [NUM_COMP*COMP_W-1:0] rd_rgb
);
   localparam int unsigned ENTRIES = 1 << IDX_W;

   logic [COMP_W-1:0] cell_w [NUM_COMP][ENTRIES];
   logic [NUM_COMP*COMP_W-1:0] rd_mux;

   for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
      for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
         localparam logic [COMP_W-1:0] INIT_V =
            (e == ENTRIES - 1) ? {COMP_W{1'b1}} : {COMP_W{1'b0}};
         logic [COMP_W-1:0] cell_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cell_q <= INIT_V;
            else if (comp_we[c] && (wr_idx == IDX_W'(e)))
               cell_q <= wr_val;
         end
         assign cell_w[c][e] = cell_q;
      end
   end

   always_comb begin
      for (int c = 0; c < NUM_COMP; c++)
         rd_mux[(NUM_COMP-1-c)*COMP_W +: COMP_W] = cell_w[c][rd_idx];
   end

   if (PIX_REG) begin : g_pix_reg
      always_ff @(posedge clk) begin
         if (!rst_n) rd_rgb <= '0;
         else        rd_rgb <= rd_mux;
      end
   end else begin : g_pix_comb
      assign rd_rgb = rd_mux;
   end
endmodule

// File: rtl/pal_dac_port.sv
module pal_dac_port
   import pal_dac_pkg::*;
#(
   parameter int unsigned IDX_W     = 8,
   parameter int unsigned COMP_W    = 8,
   parameter int unsigned BUS_W     = 32,
   parameter int unsigned WIN_BYTES = 16,
   parameter bit          PIX_REG   = 1'b1,
   localparam int unsigned ADDR_W   = $clog2(WIN_BYTES),
   localparam int unsigned BE_W     = BUS_W / 8,
   localparam int unsigned RGB_W    = NUM_COMP * COMP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BE_W-1:0]   bus_be,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [IDX_W-1:0]  pix_idx,
   output logic [RGB_W-1:0]  pix_rgb
);
   if (IDX_W > BUS_W || COMP_W > BUS_W) begin : g_bad_field
      $error("pal_dac_port: field wider than bus word");
   end
   if (ADDR_W < 3 || (1 << ADDR_W) != WIN_BYTES) begin : g_bad_win
      $error("pal_dac_port: window must be a power of two of at least 8 bytes");
   end
   if (BUS_W != 32) begin : g_bad_bus
      $error("pal_dac_port: only 32-bit words are supported");
   end

   bus_op_e             op_w;
   logic [IDX_W-1:0]    idx_w;
   comp_phase_e         phase_w;
   logic [NUM_COMP-1:0] we_w;
   logic                unused_wdata;

   assign unused_wdata = ^bus_wdata;
   assign bus_rdata    = '0;

   pal_dac_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dec (
      .wr   (bus_wr),
      .addr (bus_addr),
      .be   (bus_be),
      .op   (op_w)
   );

   pal_dac_seq #(.IDX_W(IDX_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op_w),
      .idx_in  (bus_wdata[BUS_W-1 -: IDX_W]),
      .idx_q   (idx_w),
      .phase_q (phase_w),
      .comp_we (we_w)
   );

   pal_dac_store #(.IDX_W(IDX_W), .COMP_W(COMP_W), .PIX_REG(PIX_REG)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_idx  (idx_w),
      .comp_we (we_w),
      .wr_val  (bus_wdata[BUS_W-1 -: COMP_W]),
      .rd_idx  (pix_idx),
      .rd_rgb  (pix_rgb)
   );
endmodule

// File: rtl/pal_dac_chk.sv
module pal_dac_chk
   import pal_dac_pkg::*;
#(
   parameter int unsigned IDX_W = 8,
   parameter int unsigned BUS_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic [1:0]          op,
   input logic [IDX_W-1:0]    idx_q,
   input logic [1:0]          phase_q,
   input logic [NUM_COMP-1:0] comp_we,
   input logic [BUS_W-1:0]    wdata
);
   AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_INDEX) |=> (idx_q == $past(wdata[BUS_W-1 -: IDX_W])) && (phase_q == PH_RED)); // R1
   AST_RED_TO_GREEN: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_DATA && phase_q == PH_RED) |=> (phase_q == PH_GRN) && $stable(idx_q)); // R2
   AST_GREEN_TO_BLUE: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_DATA && phase_q == PH_GRN) |=> (phase_q == PH_BLU) && $stable(idx_q)); // R2
   AST_SINGLE_COMP: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(comp_we)); // R2
   AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q != 2'd3); // R2
   AST_BLUE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_DATA && phase_q == PH_BLU) |=> (phase_q == PH_RED) && (idx_q == IDX_W'($past(idx_q) + 1'b1))); // R3
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_NONE) |=> $stable(idx_q) && $stable(phase_q)); // R7
   AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (op != OP_DATA) |-> (comp_we == '0)); // R7
endmodule

bind pal_dac_port pal_dac_chk #(.IDX_W(IDX_W), .BUS_W(BUS_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .op      (op_w),
   .idx_q   (idx_w),
   .phase_q (phase_w),
   .comp_we (we_w),
   .wdata   (bus_wdata)
);

// File: tb/tb_pal_dac_port.sv
`timescale 1ns/1ps
module tb_pal_dac_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  pix_idx = '0;
   logic [23:0] pix_rgb;

   int n_checks = 0;
   int n_errors = 0;

   always #2.5 clk = ~clk;

   pal_dac_port dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pix_idx(pix_idx), .pix_rgb(pix_rgb)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      bus_wr = 1'b0; bus_be = '0; bus_wdata = '0; bus_addr = '0;
   endtask

   task automatic set_index(input logic [7:0] i);
      do_write(4'h0, {i, 24'h5A5A5A}, 4'hF);
   endtask

   task automatic put_comp(input logic [7:0] v);
      do_write(4'h4, {v, 24'hC3C3C3}, 4'hF);
   endtask

   task automatic read_pix(input logic [7:0] i, output logic [23:0] v);
      @(negedge clk);
      pix_idx = i;
      @(negedge clk);
      v = pix_rgb;
   endtask

   task automatic t_reset;
      logic [23:0] v;
      int bad = 0;
      for (int e = 0; e < 255; e++) begin
         read_pix(8'(e), v);
         if (v !== 24'h000000) bad++;
      end
      check("R6 entries 0..254 black (mismatch count)", bad, 0);
      read_pix(8'hFF, v);
      check("R6 entry 255 white", {8'h0, v}, 32'h00FFFFFF);
      check("R4 rdata zero after reset", bus_rdata, 32'h0);
   endtask

   task automatic t_default_pointer;
      logic [23:0] v;
      put_comp(8'h11); put_comp(8'h22); put_comp(8'h33);
      read_pix(8'h00, v);
      check("R6 pointer starts at 0, phase red", {8'h0, v}, 32'h00112233);
      put_comp(8'h44);
      read_pix(8'h01, v);
      check("R3 pointer moved to 1 after blue", {8'h0, v}, 32'h00440000);
      put_comp(8'h55); put_comp(8'h66);
      read_pix(8'h01, v);
      check("R2 entry 1 completed", {8'h0, v}, 32'h00445566);
   endtask

   task automatic t_sequence;
      logic [23:0] v;
      set_index(8'h40);
      put_comp(8'hA1);
      read_pix(8'h40, v);
      check("R2 red written first", {8'h0, v}, 32'h00A10000);
      put_comp(8'hB2);
      read_pix(8'h40, v);
      check("R2 green written second", {8'h0, v}, 32'h00A1B200);
      put_comp(8'hC3);
      read_pix(8'h40, v);
      check("R1 R2 entry from index write holds all three", {8'h0, v}, 32'h00A1B2C3);
   endtask

   task automatic t_autoinc;
      logic [23:0] v;
      set_index(8'h10);
      put_comp(8'h01); put_comp(8'h02); put_comp(8'h03);
      put_comp(8'h04); put_comp(8'h05); put_comp(8'h06);
      read_pix(8'h10, v);
      check("R3 first streamed entry", {8'h0, v}, 32'h00010203);
      read_pix(8'h11, v);
      check("R3 second streamed entry", {8'h0, v}, 32'h00040506);
   endtask

   task automatic t_wrap;
      logic [23:0] v;
      set_index(8'hFF);
      put_comp(8'h12); put_comp(8'h34); put_comp(8'h56);
      put_comp(8'h9A); put_comp(8'hBC); put_comp(8'hDE);
      read_pix(8'hFF, v);
      check("R3 entry 255 written", {8'h0, v}, 32'h00123456);
      read_pix(8'h00, v);
      check("R3 pointer wrapped to 0", {8'h0, v}, 32'h009ABCDE);
   endtask

   task automatic t_restart;
      logic [23:0] v;
      set_index(8'h05);
      put_comp(8'hE1); put_comp(8'hE2);
      set_index(8'h05);
      put_comp(8'hF1); put_comp(8'hF2); put_comp(8'hF3);
      read_pix(8'h05, v);
      check("R1 index write restarts at red", {8'h0, v}, 32'h00F1F2F3);
      set_index(8'h06);
      put_comp(8'h77);
      set_index(8'h07);
      put_comp(8'h88);
      read_pix(8'h06, v);
      check("R1 abandoned entry keeps red only", {8'h0, v}, 32'h00770000);
      read_pix(8'h07, v);
      check("R1 new pointer takes red", {8'h0, v}, 32'h00880000);
   endtask

   task automatic t_ignored;
      logic [23:0] v;
      set_index(8'h20);
      put_comp(8'h01);
      do_write(4'h8, 32'hEE000000, 4'hF);
      do_write(4'hC, 32'hEE000000, 4'hF);
      read_pix(8'h20, v);
      check("R7 offsets 8 and 12 change nothing", {8'h0, v}, 32'h00010000);
      do_write(4'h5, 32'hEE000000, 4'hF);
      do_write(4'h2, 32'h33000000, 4'hF);
      check("R7 misaligned writes ignored", {8'h0, pix_rgb}, 32'h00010000);
      do_write(4'h4, 32'hEE000000, 4'h7);
      do_write(4'h0, 32'h33000000, 4'hE);
      read_pix(8'h20, v);
      check("R5 partial byte enables ignored", {8'h0, v}, 32'h00010000);
      put_comp(8'h02); put_comp(8'h03);
      read_pix(8'h20, v);
      check("R5 R7 pointer and phase kept", {8'h0, v}, 32'h00010203);
      read_pix(8'h33, v);
      check("R7 no stray entry written", {8'h0, v}, 32'h0);
   endtask

   task automatic t_reads;
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'hFFFFFFFF; bus_be = 4'hF;
      #1;
      check("R4 rdata zero during write", bus_rdata, 32'h0);
      @(negedge clk);
      bus_wr = 1'b0; bus_be = '0; bus_wdata = '0;
      check("R4 rdata zero after write", bus_rdata, 32'h0);
   endtask

   task automatic t_collision;
      logic [23:0] v;
      set_index(8'h30);
      put_comp(8'hAA); put_comp(8'hBB); put_comp(8'hCC);
      set_index(8'h30);
      @(negedge clk);
      pix_idx = 8'h30;
      bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h55000000; bus_be = 4'hF;
      @(negedge clk);
      bus_wr = 1'b0; bus_be = '0; bus_wdata = '0;
      check("R8 same-edge write returns old value", {8'h0, pix_rgb}, 32'h00AABBCC);
      @(negedge clk);
      check("R8 next lookup shows new value", {8'h0, pix_rgb}, 32'h0055BBCC);
      read_pix(8'h31, v);
      check("R8 lookup of other entry", {8'h0, v}, 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_default_pointer();
      t_sequence();
      t_autoinc();
      t_wrap();
      t_restart();
      t_ignored();
      t_reads();
      t_collision();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule